// File: doc/BRIEF.md
# Packed Unsigned-Integer to Half-Precision Converter

This block takes a vector of unsigned 32-bit integer lanes and produces a packed vector of IEEE half-precision values, one 16-bit result per input lane. A length select chooses a 128-, 256- or 512-bit source, which gives 4, 8 or 16 active lanes. Because each result is half the width of its source lane, the results occupy only the low half of the source width; every destination bit above that is cleared.

A per-lane mask decides whether each lane receives its converted value, keeps the matching lane of a supplied prior destination (merge), or is forced to zero (zeroing). When the operand is marked as coming from memory and broadcast is requested, every lane converts element 0. The rounding mode comes from a global control input unless the operand is a register, the length is 512 bits and the broadcast/rounding bit is set; in that case an embedded rounding field is used. Overflow and inexact flags from all written lanes are ORed into two single flags.

An operation is presented for one cycle with `in_valid`. The result, flags and `out_valid` appear on the next clock edge and are held until the next operation.

Top module: `pack_u2h_conv`

## Requirements
- R1: `len_sel` encodes the source length: 0 = 128 bits (lanes 0..3), 1 = 256 bits (lanes 0..7), 2 or 3 = 512 bits (lanes 0..15).
- R2: Each written lane holds the half-precision encoding (sign 0, 5-bit exponent with bias 15 in bits 14:10, 10-bit fraction in bits 9:0) of its 32-bit unsigned source, exact when the value is representable. Lane j occupies `dst_vec[16j+15:16j]`.
- R3: Rounding mode encoding: 0 = nearest, ties to even; 1 = toward minus infinity; 2 = toward plus infinity; 3 = toward zero.
- R4: A value whose rounded magnitude exceeds 65504 yields 0x7C00 (infinity) in modes 0 and 2 and 0x7BFF in modes 1 and 3, and raises both `ovf_flag` and `inexact_flag`.
- R5: `inexact_flag` is raised when any written lane's source is not exactly representable.
- R6: A lane receives its converted value when its `lane_mask` bit is 1, or for every lane when `mask_en` is 0.
- R7: With `mask_en` = 1, `zero_mode` = 1 and a lane's mask bit 0, that lane's 16 bits are zero.
- R8: With `mask_en` = 1, `zero_mode` = 0 and a lane's mask bit 0, that lane takes the matching 16 bits of `old_dst`.
- R9: With `bcast` = 1 and `src_is_mem` = 1, every active lane converts source element 0; with `src_is_mem` = 0, `bcast` causes no broadcast.
- R10: The rounding mode is `emb_rc` when `src_is_mem` = 0, length is 512 bits and `bcast` = 1; otherwise it is `glob_rc`.
- R11: All `dst_vec` bits from 16 × (active lane count) upward are zero.
- R12: Lanes that are not written (mask bit clear, or beyond the active length) contribute nothing to `ovf_flag` or `inexact_flag`.
- R13: After reset `out_valid`, `dst_vec` and both flags are zero; `out_valid` is high exactly in the cycle after an `in_valid` cycle, and results and flags hold while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle; all other inputs are captured with it |
| src_vec | input | 512 | Source lanes, 32-bit unsigned each, lane 0 in the low bits |
| old_dst | input | 256 | Prior destination lanes used by merge masking |
| lane_mask | input | 16 | Per-lane write enable, bit j for lane j |
| mask_en | input | 1 | 1 applies `lane_mask`; 0 writes every active lane |
| zero_mode | input | 1 | 1 zeroes masked-off lanes; 0 merges them |
| bcast | input | 1 | Broadcast request, or rounding override for the 512-bit register form |
| src_is_mem | input | 1 | 1 marks the operand as memory-sourced |
| len_sel | input | 2 | Source length select |
| emb_rc | input | 2 | Embedded rounding mode |
| glob_rc | input | 2 | Global rounding mode |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| dst_vec | output | 512 | Packed half-precision result, upper bits cleared |
| ovf_flag | output | 1 | OR of overflow over written lanes |
| inexact_flag | output | 1 | OR of inexact over written lanes |

## Verification
A wrong rounding decision or leading-one position inside a lane converter shows at the next clock edge as a wrong 16-bit lane value, and usually as a wrong inexact or overflow flag in that same cycle. A mis-decoded length, mask or broadcast selection shows immediately as a lane holding a value from the wrong source or a nonzero bit above the active region. Since every operation is checked in the cycle after it is issued, and the held outputs are checked again the cycle after that, a corruption is reported in the cycle it occurs rather than accumulating.

// File: rtl/u2h_pkg.sv
// Package u2h_pkg
// Shared types and helpers for the packed integer-to-half converter.
// Assumes half-precision results (1/5/10 format) and a 2-bit length code.
package u2h_pkg;

    // Rounding modes, in the encoding used at the block's ports
    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_DOWN = 2'd1,
        RM_UP   = 2'd2,
        RM_ZERO = 2'd3
    } rmode_t;

    // Length codes
    localparam logic [1:0] LEN_Q = 2'd0;   // quarter of the maximum source
    localparam logic [1:0] LEN_H = 2'd1;   // half of the maximum source

    // Half-precision format constants
    localparam int unsigned HP_MANT = 10;
    localparam int unsigned HP_BIAS = 15;
    localparam int unsigned HP_EMAX = 30;
    localparam logic [15:0] HP_INF  = 16'h7C00;
    localparam logic [15:0] HP_MAXF = 16'h7BFF;

    // Active lane count for a length code
    function automatic int unsigned active_lanes(input logic [1:0] len, input int unsigned max_lanes);
        case (len)
            LEN_Q:   return max_lanes / 4;
            LEN_H:   return max_lanes / 2;
            default: return max_lanes;
        endcase
    endfunction

    // True when the length code selects the full source width
    function automatic logic is_full_len(input logic [1:0] len);
        return (len != LEN_Q) && (len != LEN_H);
    endfunction

endpackage

// File: rtl/u2h_scalar.sv
// Module u2h_scalar
// Combinational conversion of one unsigned integer to half precision
// under a selectable rounding mode. Reports overflow and inexact.
// Assumes IN_W > HP_MANT + 1 and a non-negative (unsigned) input.
module u2h_scalar
    import u2h_pkg::*;
#(
    parameter int unsigned IN_W = 32
) (
    input  logic [IN_W-1:0] val,
    input  rmode_t          rm,
    output logic [15:0]     half,
    output logic            ovf,
    output logic            inexact
);
    localparam int unsigned POS_W = $clog2(IN_W);
    localparam int unsigned EXP_W = POS_W + 2;
    localparam logic [POS_W-1:0] MANT_POS = POS_W'(HP_MANT);
    localparam logic [EXP_W-1:0] BIAS_E   = EXP_W'(HP_BIAS);
    localparam logic [EXP_W-1:0] EMAX_E   = EXP_W'(HP_EMAX);

    logic [POS_W-1:0]   lead;
    logic [POS_W-1:0]   shamt;
    logic [IN_W-1:0]    up_shift;
    logic [IN_W-1:0]    kept;
    logic [IN_W-1:0]    low_mask;
    logic               guard_b;
    logic               sticky_b;
    logic               rnd_up;
    logic [HP_MANT+1:0] sum;
    logic [EXP_W-1:0]   exp_b;
    logic [HP_MANT-1:0] frac;

    // Find the position of the most significant set bit
    always_comb begin
        lead = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (val[i]) lead = POS_W'(i);
        end
    end

    // Normalise, round and pack the result
    always_comb begin
        shamt    = '0;
        up_shift = '0;
        kept     = '0;
        low_mask = '0;
        guard_b  = 1'b0;
        sticky_b = 1'b0;
        rnd_up   = 1'b0;
        sum      = '0;
        exp_b    = '0;
        frac     = '0;
        half     = '0;
        ovf      = 1'b0;
        inexact  = 1'b0;
        if (val != '0) begin
            if (lead <= MANT_POS) begin
                up_shift = val << (MANT_POS - lead);
                frac     = up_shift[HP_MANT-1:0];
                exp_b    = EXP_W'(lead) + BIAS_E;
            end else begin
                shamt    = lead - MANT_POS;
                kept     = val >> shamt;
                low_mask = ~({IN_W{1'b1}} << shamt);
                inexact  = |(val & low_mask);
                guard_b  = |(val & (low_mask ^ (low_mask >> 1)));
                sticky_b = |(val & (low_mask >> 1));
                case (rm)
                    RM_NEAR: rnd_up = guard_b & (sticky_b | kept[0]);
                    RM_UP:   rnd_up = inexact;
                    default: rnd_up = 1'b0;
                endcase
                sum = {1'b0, kept[HP_MANT:0]} + (HP_MANT+2)'(rnd_up);
                if (sum[HP_MANT+1]) begin
                    exp_b = EXP_W'(lead) + BIAS_E + EXP_W'(1);
                    frac  = '0;
                end else begin
                    exp_b = EXP_W'(lead) + BIAS_E;
                    frac  = sum[HP_MANT-1:0];
                end
            end
            if (exp_b > EMAX_E) begin
                ovf     = 1'b1;
                inexact = 1'b1;
                half    = (rm == RM_NEAR || rm == RM_UP) ? HP_INF : HP_MAXF;
            end else begin
                half = {1'b0, exp_b[4:0], frac};
            end
        end
    end

endmodule

// File: rtl/u2h_lane.sv
// Module u2h_lane
// One output lane: converts its selected source element and applies
// the write mask (write, merge or zero) and the length cut-off.
// Flags leave the lane only when the lane is actually written.
module u2h_lane
    import u2h_pkg::*;
#(
    parameter int unsigned IN_W  = 32,
    parameter int unsigned OUT_W = 16
) (
    input  logic [IN_W-1:0]  elem,
    input  logic [OUT_W-1:0] old_elem,
    input  rmode_t           rm,
    input  logic             active,
    input  logic             wr_en,
    input  logic             zero_mode,
    output logic [OUT_W-1:0] res,
    output logic             ovf,
    output logic             inexact
);
    logic [15:0] conv;
    logic        c_ovf;
    logic        c_inx;

    u2h_scalar #(.IN_W(IN_W)) u_cvt (
        .val     (elem),
        .rm      (rm),
        .half    (conv),
        .ovf     (c_ovf),
        .inexact (c_inx)
    );

    // Select converted, merged or zero lane value
    always_comb begin
        if (!active)                res = '0;
        else if (wr_en)             res = OUT_W'(conv);
        else if (zero_mode)         res = '0;
        else                        res = old_elem;
    end

    // Gate flags to written lanes only
    always_comb begin
        ovf     = active & wr_en & c_ovf;
        inexact = active & wr_en & c_inx;
    end

endmodule

// File: rtl/pack_u2h_conv.sv
// Module pack_u2h_conv
// Packed, masked conversion of unsigned integer lanes to half precision.
// Selects the rounding mode and broadcast source, runs one converter per
// lane, clears bits above the active region and registers the result.
// Assumes OUT_W = 16 and MAX_LANES divisible by 4.
module pack_u2h_conv
    import u2h_pkg::*;
#(
    parameter int unsigned MAX_LANES = 16,
    parameter int unsigned IN_W      = 32,
    parameter int unsigned OUT_W     = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [MAX_LANES*IN_W-1:0]     src_vec,
    input  logic [MAX_LANES*OUT_W-1:0]    old_dst,
    input  logic [MAX_LANES-1:0]          lane_mask,
    input  logic                          mask_en,
    input  logic                          zero_mode,
    input  logic                          bcast,
    input  logic                          src_is_mem,
    input  logic [1:0]                    len_sel,
    input  logic [1:0]                    emb_rc,
    input  logic [1:0]                    glob_rc,
    output logic                          out_valid,
    output logic [MAX_LANES*IN_W-1:0]     dst_vec,
    output logic                          ovf_flag,
    output logic                          inexact_flag
);
    localparam int unsigned SRC_W  = MAX_LANES * IN_W;
    localparam int unsigned PACK_W = MAX_LANES * OUT_W;
    localparam int unsigned Q_W    = (MAX_LANES / 4) * OUT_W;

    int unsigned          n_act;
    logic                 use_emb;
    logic                 do_bcast;
    rmode_t               rm_sel;
    logic [PACK_W-1:0]    packed_res;
    logic [MAX_LANES-1:0] lane_ovf;
    logic [MAX_LANES-1:0] lane_inx;

    logic [SRC_W-1:0]     dst_q;
    logic                 valid_q;
    logic                 ovf_q;
    logic                 inx_q;
    logic [1:0]           len_q;

    // Decode length, broadcast and rounding source for this operation
    always_comb begin
        n_act    = active_lanes(len_sel, MAX_LANES);
        use_emb  = !src_is_mem && is_full_len(len_sel) && bcast;
        do_bcast = src_is_mem && bcast;
        rm_sel   = use_emb ? rmode_t'(emb_rc) : rmode_t'(glob_rc);
    end

    generate
        for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
            logic [IN_W-1:0] elem;
            // Pick own element or element 0 when broadcasting
            always_comb elem = do_bcast ? src_vec[IN_W-1:0] : src_vec[j*IN_W +: IN_W];

            u2h_lane #(.IN_W(IN_W), .OUT_W(OUT_W)) u_lane (
                .elem      (elem),
                .old_elem  (old_dst[j*OUT_W +: OUT_W]),
                .rm        (rm_sel),
                .active    (j < n_act),
                .wr_en     (!mask_en || lane_mask[j]),
                .zero_mode (zero_mode),
                .res       (packed_res[j*OUT_W +: OUT_W]),
                .ovf       (lane_ovf[j]),
                .inexact   (lane_inx[j])
            );
        end
    endgenerate

    // Capture the result, flags and length on each accepted operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            dst_q   <= '0;
            ovf_q   <= 1'b0;
            inx_q   <= 1'b0;
            len_q   <= LEN_Q;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                dst_q <= {{(SRC_W-PACK_W){1'b0}}, packed_res};
                ovf_q <= |lane_ovf;
                inx_q <= |lane_inx;
                len_q <= len_sel;
            end
        end
    end

    always_comb begin
        out_valid    = valid_q;
        dst_vec      = dst_q;
        ovf_flag     = ovf_q;
        inexact_flag = inx_q;
    end

    // R13
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R13
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R13
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dst_vec) && $stable(ovf_flag) && $stable(inexact_flag)));
    // R4
    ovf_implies_inx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> inexact_flag);
    // R11
    quarter_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && len_q == LEN_Q) |-> (dst_vec[SRC_W-1:Q_W] == '0));
    // R7
    zero_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && zero_mode && lane_mask == '0) |=> (dst_vec == '0));
    // R12
    no_flag_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && lane_mask == '0) |=> (!ovf_flag && !inexact_flag));

endmodule

// File: tb/pack_u2h_conv_test.sv
module pack_u2h_conv_test;
    localparam int NL = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [511:0]   s_src = '0;
    logic [255:0]   s_old = '0;
    logic [15:0]    s_mask = '0;
    logic           s_men = 1'b0;
    logic           s_zero = 1'b0;
    logic           s_bc = 1'b0;
    logic           s_mem = 1'b0;
    logic [1:0]     s_len = 2'd0;
    logic [1:0]     s_emb = 2'd0;
    logic [1:0]     s_glob = 2'd0;
    logic           out_valid;
    logic [511:0]   dst_vec;
    logic           ovf_flag;
    logic           inexact_flag;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #2 clk = ~clk;

    pack_u2h_conv uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_vec(s_src), .old_dst(s_old), .lane_mask(s_mask),
        .mask_en(s_men), .zero_mode(s_zero), .bcast(s_bc),
        .src_is_mem(s_mem), .len_sel(s_len), .emb_rc(s_emb),
        .glob_rc(s_glob), .out_valid(out_valid), .dst_vec(dst_vec),
        .ovf_flag(ovf_flag), .inexact_flag(inexact_flag)
    );

    task automatic rnd(output logic [31:0] r);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        r = seed;
    endtask

    task automatic gen_val(output logic [31:0] v);
        logic [31:0] a, b;
        rnd(a); rnd(b);
        case (b[1:0])
            2'd0: v = a >> b[7:3];
            2'd1: v = a & 32'h0001_FFFF;
            2'd2: v = (32'd1 << b[12:8]) + {28'd0, b[19:16]} - 32'd8;
            default: v = a;
        endcase
    endtask

    // Arithmetic reference for one conversion
    task automatic ref_cvt(input logic [31:0] x, input int rm,
                           output logic [15:0] h, output bit ovf, output bit inx);
        longint v, q, r, hf, up;
        int e, s;
        v = longint'(x);
        ovf = 0; inx = 0; h = 16'h0;
        if (v == 0) return;
        e = 0;
        while ((v >> (e + 1)) != 0) e++;
        if (e <= 10) begin
            q = (v << (10 - e)) - 1024;
            h = 16'(((e + 15) << 10) + q);
            return;
        end
        s = e - 10;
        q = v / (longint'(1) << s);
        r = v % (longint'(1) << s);
        hf = longint'(1) << (s - 1);
        up = 0;
        if (rm == 0) up = (r > hf || (r == hf && q % 2 == 1)) ? 1 : 0;
        else if (rm == 2) up = (r != 0) ? 1 : 0;
        q = q + up;
        if (q == 2048) begin q = 1024; e++; end
        inx = (r != 0);
        if (e + 15 > 30) begin
            ovf = 1; inx = 1;
            h = (rm == 0 || rm == 2) ? 16'h7C00 : 16'h7BFF;
        end else begin
            h = 16'(((e + 15) << 10) + (q - 1024));
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one operation from the s_* settings and check the result
    task automatic apply(input string req);
        logic [511:0] exp_dst;
        bit exp_o, exp_i, lo, li;
        logic [15:0] h;
        int nl, rm, bad;
        logic [511:0] held;
        exp_dst = '0; exp_o = 0; exp_i = 0;
        nl = (s_len == 2'd0) ? 4 : (s_len == 2'd1) ? 8 : 16;
        rm = (!s_mem && s_len >= 2'd2 && s_bc) ? int'(s_emb) : int'(s_glob);
        for (int j = 0; j < nl; j++) begin
            if (!s_men || s_mask[j]) begin
                ref_cvt((s_mem && s_bc) ? s_src[31:0] : s_src[j*32 +: 32], rm, h, lo, li);
                exp_dst[j*16 +: 16] = h;
                exp_o |= lo; exp_i |= li;
            end else if (!s_zero) begin
                exp_dst[j*16 +: 16] = s_old[j*16 +: 16];
            end
        end
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R13", "out_valid after op", 64'(out_valid), 64'd1);
        bad = -1;
        for (int j = 31; j >= 0; j--) if (dst_vec[j*16 +: 16] != exp_dst[j*16 +: 16]) bad = j;
        if (bad < 0) check(1, req, "dst", 0, 0);
        else check(0, req, $sformatf("dst lane %0d", bad),
                   64'(dst_vec[bad*16 +: 16]), 64'(exp_dst[bad*16 +: 16]));
        check({ovf_flag, inexact_flag} == {exp_o, exp_i}, req, "flags {ovf,inx}",
              64'({ovf_flag, inexact_flag}), 64'({exp_o, exp_i}));
        held = dst_vec;
        s_src = ~s_src;
        @(negedge clk);
        check(out_valid == 1'b0 && dst_vec == held && {ovf_flag, inexact_flag} == {exp_o, exp_i},
              "R13", "hold while idle", 64'({out_valid, ovf_flag, inexact_flag}),
              64'({1'b0, exp_o, exp_i}));
    endtask

    task automatic fill_src();
        logic [31:0] v;
        for (int j = 0; j < NL; j++) begin gen_val(v); s_src[j*32 +: 32] = v; end
    endtask

    task automatic fill_old();
        logic [31:0] v;
        for (int j = 0; j < 8; j++) begin rnd(v); s_old[j*32 +: 32] = v; end
    endtask

    task automatic plain();
        s_men = 0; s_zero = 0; s_bc = 0; s_mem = 0; s_len = 2'd2;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check(out_valid == 0 && dst_vec == '0 && !ovf_flag && !inexact_flag, "R13",
              "reset state", 64'({out_valid, ovf_flag, inexact_flag, |dst_vec}), 64'd0);

        // R2 R3 R5: conversion sweep in every rounding mode
        for (int rm = 0; rm < 4; rm++) begin
            for (int k = 0; k < 150; k++) begin
                plain(); s_glob = 2'(rm); fill_src(); apply("R2");
            end
        end

        // R4 R3: boundary values near the top of the range
        for (int rm = 0; rm < 4; rm++) begin
            plain(); s_glob = 2'(rm);
            s_src = {32'd65504, 32'd65505, 32'd65519, 32'd65520, 32'd65535, 32'd65536,
                     32'hFFFF_FFFF, 32'd2047, 32'd2048, 32'd2049, 32'd2050, 32'd2051,
                     32'd4095, 32'd4097, 32'd0, 32'd1};
            apply("R4");
            s_src = {16{32'd65520}};
            apply("R3");
        end

        // R1 R11: every length code with random data
        for (int l = 0; l < 4; l++) begin
            for (int k = 0; k < 20; k++) begin
                plain(); s_len = 2'(l); rnd(m); s_glob = m[1:0];
                fill_src(); fill_old(); apply(l == 3 ? "R1" : "R11");
            end
        end

        // R6 R7 R8: masking modes
        for (int k = 0; k < 60; k++) begin
            plain(); rnd(m); s_len = m[5:4]; s_mask = m[31:16]; s_glob = m[1:0];
            fill_src(); fill_old();
            case (k % 3)
                0: begin s_men = 1; s_zero = 0; apply("R8"); end
                1: begin s_men = 1; s_zero = 1; apply("R7"); end
                default: begin s_men = 0; s_zero = m[2]; apply("R6"); end
            endcase
        end

        // R12: overflowing lanes masked off or outside the length
        plain(); s_men = 1; s_mask = 16'h5555;
        for (int j = 0; j < NL; j++) s_src[j*32 +: 32] = (j % 2) ? 32'hFFFF_FFFF : 32'd100;
        apply("R12");
        plain(); s_len = 2'd0;
        for (int j = 0; j < NL; j++) s_src[j*32 +: 32] = (j < 4) ? 32'd7 : 32'h8000_0001;
        apply("R12");
        plain(); s_men = 1; s_mask = 16'h0000; s_zero = 0; fill_src(); fill_old();
        apply("R12");

        // R9: broadcast from memory vs register source
        for (int l = 0; l < 3; l++) begin
            plain(); s_len = 2'(l); s_bc = 1; s_mem = 1; fill_src(); s_src[31:0] = 32'd70001;
            rnd(m); s_glob = m[1:0]; apply("R9");
            plain(); s_len = 2'(l); s_bc = 1; s_mem = 0; fill_src(); s_glob = 2'd0;
            s_emb = 2'd0; apply("R9");
        end

        // R10: rounding override only on the full-length register form
        for (int g = 0; g < 4; g++) begin
            for (int e = 0; e < 4; e++) begin
                plain(); s_glob = 2'(g); s_emb = 2'(e); s_bc = 1;
                s_src = {16{32'd2049}}; s_src[63:32] = 32'd2051; s_src[95:64] = 32'd70000;
                s_mem = 0; s_len = 2'd2; apply("R10");
                s_mem = 0; s_len = 2'd1; s_src = {16{32'd2051}}; apply("R10");
                s_mem = 1; s_len = 2'd2; apply("R10");
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule